// File: doc/BRIEF.md
# Next-Instruction Address Selector

This block computes the address of the next instruction fetch for a 32-bit processor whose instructions are all four bytes long. Each cycle it takes the address of the instruction now executing, a flag saying whether a branch is taken, a two-bit selector for how the branch target is formed, a 24-bit displacement from the instruction word, and the current link and count register contents. It then loads the chosen address into a program-counter register.

With no branch taken, the next address is the current one plus four. A taken branch goes to one of four targets. The first is an offset from the current address. The second is an absolute location formed from the displacement alone. The third is the link register and the fourth is the count register. The displacement is always a signed word count, so it is scaled by four before use. Register targets have their two low bits cleared, so every fetch address stays word aligned.

The register resets synchronously to a parameter-set vector. It holds its value while a stall input is high. Branch condition evaluation and updates to the link and count registers happen outside this block.

Top module: `next_pc_sel`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes `RESET_VEC` (default 32'h0000_0100) after that edge.
- R2: When `stall` is high and `rst` low at a rising edge, `pc` keeps its previous value.
- R3: When `br_taken` is low, the next `pc` is `cur_addr + 4`, whatever the values of `br_mode`, `disp`, `lr` and `ctr`.
- R4: With `br_taken` high and `br_mode` = 2'b00 (relative), the next `pc` is `cur_addr` plus `disp` shifted left by two and sign-extended from bit 25 to 32 bits.
- R5: With `br_taken` high and `br_mode` = 2'b01 (absolute), the next `pc` is `disp` shifted left by two and sign-extended from bit 25, independent of `cur_addr`.
- R6: With `br_taken` high and `br_mode` = 2'b10 (link), the next `pc` is `lr` with bits 1:0 cleared.
- R7: With `br_taken` high and `br_mode` = 2'b11 (count), the next `pc` is `ctr` with bits 1:0 cleared.
- R8: Sequential and relative additions wrap modulo 2^32 (for example, 32'hFFFF_FFFC + 4 gives 0).
- R9: `rst` takes priority over `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the program counter |
| cur_addr | input | 32 | Address of the current instruction |
| br_taken | input | 1 | Branch taken |
| br_mode | input | 2 | Target form: 00 relative, 01 absolute, 10 link, 11 count |
| disp | input | 24 | Signed word displacement |
| lr | input | 32 | Link register value |
| ctr | input | 32 | Count register value |
| pc | output | 32 | Registered next fetch address |

## Verification
The hardest cases are those where the sign extension and the low-bit clearing are visible. These need a negative displacement in absolute mode, and register targets whose low bits are set. The stimulus gives them directly and also sets those low bits on idle cycles. Reaching the 2^32 wrap needs a current address near the top of memory. So the bench drives `cur_addr` next to 32'hFFFF_FFFC, both with a positive relative offset and on a plain sequential step. Stall and reset are raised together so that the priority between them can be seen in one cycle.

// File: rtl/next_pc_sel.sv
module next_pc_sel #(
  parameter int          AW        = 32,
  parameter int          DW        = 24,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic [AW-1:0] cur_addr,
  input  logic          br_taken,
  input  logic [1:0]    br_mode,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] lr,
  input  logic [AW-1:0] ctr,
  output logic [AW-1:0] pc
);
  localparam int SW = DW + 2;

  logic [SW-1:0] disp_sh;
  logic [AW-1:0] disp_ext, target, nxt;

  assign disp_sh  = {disp, 2'b00};
  assign disp_ext = {{(AW-SW){disp_sh[SW-1]}}, disp_sh};

  always_comb begin
    unique case (br_mode)
      2'b00:   target = cur_addr + disp_ext;
      2'b01:   target = disp_ext;
      2'b10:   target = {lr[AW-1:2], 2'b00};
      default: target = {ctr[AW-1:2], 2'b00};
    endcase
  end

  assign nxt = br_taken ? target : cur_addr + AW'(4);

  always_ff @(posedge clk) begin
    if (rst)         pc <= RESET_VEC[AW-1:0];
    else if (!stall) pc <= nxt;
  end

  // R1
  reset_vec_chk: assert property (@(posedge clk) rst |=> pc == RESET_VEC[AW-1:0]);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst) stall |=> $stable(pc));
  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !br_taken) |=> pc == $past(cur_addr) + AW'(4));
  // R5
  abs_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_taken && br_mode == 2'b01) |=> pc[1:0] == 2'b00 && pc[AW-1:SW-1] == {(AW-SW+1){$past(disp[DW-1])}});
  // R6
  link_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_taken && br_mode == 2'b10) |=> pc[AW-1:2] == $past(lr[AW-1:2]) && pc[1:0] == 2'b00);
  // R7
  count_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_taken && br_mode == 2'b11) |=> pc[AW-1:2] == $past(ctr[AW-1:2]) && pc[1:0] == 2'b00);
endmodule

// File: tb/test_next_pc_sel.sv
`timescale 1ns/1ps
module test_next_pc_sel;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 0, rst, stall, br_taken;
  logic [31:0] cur_addr, lr, ctr, pc;
  logic [1:0]  br_mode;
  logic [23:0] disp;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model_pc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  next_pc_sel i_next_pc_sel (.clk, .rst, .stall, .cur_addr, .br_taken,
    .br_mode, .disp, .lr, .ctr, .pc);

  function automatic logic [31:0] sx(input logic [23:0] d);
    return {{6{d[23]}}, d, 2'b00};
  endfunction

  task automatic drive(input logic r, s, t, input logic [1:0] m,
                       input logic [23:0] d, input logic [31:0] a, l, c,
                       input string tag);
    @(negedge clk);
    rst = r; stall = s; br_taken = t; br_mode = m; disp = d;
    cur_addr = a; lr = l; ctr = c;
    if (r)       model_pc = RV;
    else if (!s) begin
      if (!t)              model_pc = a + 32'd4;
      else if (m == 2'b00) model_pc = a + sx(d);
      else if (m == 2'b01) model_pc = sx(d);
      else if (m == 2'b10) model_pc = l & 32'hFFFF_FFFC;
      else                 model_pc = c & 32'hFFFF_FFFC;
    end
    exp_q.push_back(model_pc);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (pc !== e) begin
        errors++;
        $display("FAIL %s: pc=%h expected=%h", tg, pc, e);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_pc = RV;
    // R1 reset
    drive(1, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, "R1");
    drive(1, 0, 1, 2'b10, 0, 32'h40, 32'h1234, 32'h0, "R1");
    // R3 sequential, other fields ignored
    drive(0, 0, 0, 2'b10, 24'h00_0010, 32'h0000_2000, 32'hDEAD_BEE3, 32'h5555_5557, "R3");
    drive(0, 0, 0, 2'b01, 24'hFF_FFFF, 32'h0000_2004, 32'h0, 32'h0, "R3");
    // R4 relative positive and negative
    drive(0, 0, 1, 2'b00, 24'h00_0040, 32'h0000_3000, 32'h0, 32'h0, "R4");
    drive(0, 0, 1, 2'b00, 24'hFF_FFF0, 32'h0000_3000, 32'h0, 32'h0, "R4");
    // R5 absolute positive and negative (sign extension)
    drive(0, 0, 1, 2'b01, 24'h12_3456, 32'h0000_3000, 32'h0, 32'h0, "R5");
    drive(0, 0, 1, 2'b01, 24'h80_0001, 32'h0000_7770, 32'h0, 32'h0, "R5");
    // R6 link, low bits set
    drive(0, 0, 1, 2'b10, 24'h0, 32'h0, 32'hCAFE_F00F, 32'h1, "R6");
    // R7 count, low bits set
    drive(0, 0, 1, 2'b11, 24'h0, 32'h0, 32'h3, 32'h8765_4323, "R7");
    // R2 stall holds
    drive(0, 1, 1, 2'b10, 24'h0, 32'h0, 32'h1111_0000, 32'h0, "R2");
    drive(0, 1, 0, 2'b00, 24'h0, 32'h4000, 32'h0, 32'h0, "R2");
    // R8 wrap on sequential and relative
    drive(0, 0, 0, 2'b00, 24'h0, 32'hFFFF_FFFC, 32'h0, 32'h0, "R8");
    drive(0, 0, 1, 2'b00, 24'h00_0004, 32'hFFFF_FFF8, 32'h0, 32'h0, "R8");
    // R9 reset beats stall
    drive(0, 0, 1, 2'b11, 24'h0, 32'h0, 32'h0, 32'hAAAA_AAA8, "R7");
    drive(1, 1, 1, 2'b10, 24'h0, 32'h0, 32'h9999_9998, 32'h0, "R9");
    drive(0, 0, 0, 2'b00, 24'h0, 32'h0000_0100, 32'h0, 32'h0, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule